// File: doc/BRIEF.md
# Byte-Wide Serial Peripheral Port with Buffered Receive

This block is a full-duplex, byte-wide SPI port that a host processor drives through two registers: a data register and a combined configuration/status register. It can run as the bus master, generating the serial clock itself, or as a slave that follows an incoming clock. One shift register sends and receives at the same time. At the end of each byte, the received value is copied into a separate receive buffer, so host reads never see bits that are still moving through the shift register.

A transfer-complete flag marks the end of every byte. While the flag is pending and the host has not yet read the status register, writes to the data register are dropped. A status read followed by any data-register access clears the flag. The slave-select input can come from the external pin or from a software bit. A configuration bit can also turn off the serial data output driver.

Only serial mode 0 is supported: the clock idles low, bits are sampled on the rising edge, data changes on the falling edge, and the most significant bit goes first. In master mode the serial clock runs at the system clock divided by four.

Top module: `spi_byte_port`

## Requirements
- R1: In master mode (enable=1, master=1), an accepted write to the data register (busAddr=0) loads the byte into the shift register and produces exactly 8 serial clock pulses. The clock period is 4 system clocks (2 high, 2 low), and the clock idles low before and after the transfer.
- R2: When the last bit completes, the transfer-complete flag (status bit 7) is set and the received byte is copied into the receive buffer. Bits move most significant first.
- R3: A read of the data register returns the receive buffer. The buffer keeps its previous value while the next transfer is in progress.
- R4: While the flag is set and the status register (busAddr=1) has not been read since it was set, data-register writes are ignored. They neither start a transfer nor change the shift register.
- R5: Once the flag is set, a status read followed by a data-register read or write clears it, and a data-register read alone does not. After the status read, a data-register write is accepted.
- R6: Configuration bits [4:0] are {softSelVal, softSelMgmt, outDisable, master, enable}. The data output enables mosiOe (master) and misoOe (selected slave) are high only when enable=1 and outDisable=0. sckOe follows enable and master.
- R7: With softSelMgmt=1, the internal select is softSelVal (0 = selected, 1 = deselected) and ssPinN is ignored. With softSelMgmt=0, ssPinN selects the slave (active low).
- R8: A deselected slave ignores the serial clock. Its bit counter returns to zero on deselection, so a byte cut short raises no flag, and the next full byte is received whole.
- R9: The master changes mosiO only on falling serial clock edges. A master and a slave wired back to back exchange their loaded bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Host access strobe, one cycle per access |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 1 | 0 = data register, 1 = configuration/status register |
| busWdata | input | 8 | Host write data |
| busRdata | output | 8 | Host read data (combinational on busAddr) |
| sckI | input | 1 | Serial clock input (slave mode) |
| sckO | output | 1 | Serial clock output (master mode) |
| sckOe | output | 1 | Serial clock output enable |
| mosiI | input | 1 | Serial data in, used as slave |
| mosiO | output | 1 | Serial data out, used as master |
| mosiOe | output | 1 | Master data output enable |
| misoI | input | 1 | Serial data in, used as master |
| misoO | output | 1 | Serial data out, used as slave |
| misoOe | output | 1 | Slave data output enable |
| ssPinN | input | 1 | External slave select, active low |

## Verification
After the system edge that accepts a data write, the master's serial clock rises 2 cycles later and then every 4 cycles. Its flag sets 32 cycles after the write, and the slave's flag sets one cycle after the master's, because the slave sees edges through a single register stage. The bench therefore samples the serial lines at every falling system edge for a 40-cycle window after each write, and reads flags and buffers only after that window has closed. The output-enable and read-data paths are combinational, so they are checked one half cycle after the register write or address change that drives them.

// File: rtl/spi_byte_pkg.sv
`timescale 1ns/1ps
package spi_byte_pkg;

  localparam logic ADDR_DATA = 1'b0;
  localparam logic ADDR_STAT = 1'b1;

  typedef struct packed {
    logic softSelVal;
    logic softSelMgmt;
    logic outDisable;
    logic master;
    logic enable;
  } cfg_t;

  typedef struct packed {
    logic loadShift;
    logic sampleBit;
    logic shiftBit;
    logic capture;
    logic srcMaster;
  } strobes_t;

endpackage

// File: rtl/spi_byte_ctrl.sv
`timescale 1ns/1ps
module spi_byte_ctrl
  import spi_byte_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int CLK_DIV = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busSel,
  input  logic       busWr,
  input  logic       busAddr,
  input  logic [4:0] cfgWdata,
  input  logic       sckI,
  input  logic       ssPinN,
  output strobes_t   stb,
  output cfg_t       cfgQ,
  output logic       flagQ,
  output logic       seenQ,
  output logic       busyQ,
  output logic       sckO,
  output logic       slvActive
);

  localparam int PH_W  = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam int HALF  = CLK_DIV / 2;
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [PH_W-1:0]  PH_RISE = PH_W'(HALF - 1);
  localparam logic [PH_W-1:0]  PH_FALL = PH_W'(CLK_DIV - 1);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(DATA_W - 1);

  logic [PH_W-1:0]  phase;
  logic [CNT_W-1:0] bitCnt;
  logic             sckPrev;
  logic             dataAcc, dataWr, statRd, statWr, wrOk, startM;
  logic             selN, riseS, fallS, sampleM, shiftM;

  always_comb begin
    dataAcc   = busSel && (busAddr == ADDR_DATA);
    dataWr    = dataAcc && busWr;
    statRd    = busSel && !busWr && (busAddr == ADDR_STAT);
    statWr    = busSel && busWr && (busAddr == ADDR_STAT);
    wrOk      = dataWr && !(flagQ && !seenQ) && !busyQ;
    startM    = wrOk && cfgQ.enable && cfgQ.master;
    selN      = cfgQ.softSelMgmt ? cfgQ.softSelVal : ssPinN;
    slvActive = cfgQ.enable && !cfgQ.master && !selN;
    riseS     = slvActive && sckI && !sckPrev;
    fallS     = slvActive && !sckI && sckPrev;
    sampleM   = busyQ && (phase == PH_RISE);
    shiftM    = busyQ && (phase == PH_FALL);
    stb.loadShift = wrOk;
    stb.sampleBit = sampleM || riseS;
    stb.shiftBit  = shiftM || fallS;
    stb.capture   = (shiftM || fallS) && (bitCnt == CNT_END);
    stb.srcMaster = cfgQ.master;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ <= '0;
    end else if (statWr) begin
      cfgQ <= cfgWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      phase <= '0;
      sckO  <= 1'b0;
    end else if (!cfgQ.enable || !cfgQ.master) begin
      busyQ <= 1'b0;
      phase <= '0;
      sckO  <= 1'b0;
    end else if (startM) begin
      busyQ <= 1'b1;
      phase <= '0;
      sckO  <= 1'b0;
    end else if (busyQ) begin
      phase <= (phase == PH_FALL) ? '0 : phase + 1'b1;
      if (sampleM) sckO <= 1'b1;
      if (shiftM) begin
        sckO <= 1'b0;
        if (bitCnt == CNT_END) busyQ <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt  <= '0;
      sckPrev <= 1'b0;
    end else begin
      sckPrev <= sckI;
      if (startM) begin
        bitCnt <= '0;
      end else if (stb.shiftBit) begin
        bitCnt <= (bitCnt == CNT_END) ? '0 : bitCnt + 1'b1;
      end else if (!cfgQ.master && !slvActive) begin
        bitCnt <= '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ <= 1'b0;
      seenQ <= 1'b0;
    end else begin
      if (stb.capture) flagQ <= 1'b1;
      else if (dataAcc && seenQ) flagQ <= 1'b0;
      if (dataAcc && seenQ) seenQ <= 1'b0;
      else if (statRd && flagQ) seenQ <= 1'b1;
    end
  end

endmodule

// File: rtl/spi_byte_dp.sv
`timescale 1ns/1ps
module spi_byte_dp
  import spi_byte_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stb,
  input  logic [DATA_W-1:0] wdata,
  input  logic              misoI,
  input  logic              mosiI,
  output logic [DATA_W-1:0] shiftQ,
  output logic [DATA_W-1:0] rxBufQ,
  output logic              serOut
);

  logic rxBit;
  logic serIn;
  logic [DATA_W-1:0] shiftNext;

  always_comb begin
    serIn     = stb.srcMaster ? misoI : mosiI;
    shiftNext = {shiftQ[DATA_W-2:0], rxBit};
    serOut    = shiftQ[DATA_W-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ <= '0;
      rxBit  <= 1'b0;
      rxBufQ <= '0;
    end else begin
      if (stb.loadShift) shiftQ <= wdata;
      else if (stb.shiftBit) shiftQ <= shiftNext;
      if (stb.sampleBit) rxBit <= serIn;
      if (stb.capture) rxBufQ <= shiftNext;
    end
  end

endmodule

// File: rtl/spi_byte_port.sv
`timescale 1ns/1ps
module spi_byte_port
  import spi_byte_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int CLK_DIV = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic              busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              sckI,
  output logic              sckO,
  output logic              sckOe,
  input  logic              mosiI,
  output logic              mosiO,
  output logic              mosiOe,
  input  logic              misoI,
  output logic              misoO,
  output logic              misoOe,
  input  logic              ssPinN
);

  localparam int PAD_W = DATA_W - 6;

  strobes_t          stb;
  cfg_t              cfgQ;
  logic              flagQ, seenQ, busyQ, slvActive, serOut;
  logic [DATA_W-1:0] shiftQ, rxBufQ;

  spi_byte_ctrl #(.DATA_W(DATA_W), .CLK_DIV(CLK_DIV)) ctrl_i (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .cfgWdata(busWdata[4:0]), .sckI(sckI), .ssPinN(ssPinN), .stb(stb),
    .cfgQ(cfgQ), .flagQ(flagQ), .seenQ(seenQ), .busyQ(busyQ), .sckO(sckO),
    .slvActive(slvActive)
  );

  spi_byte_dp #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .wdata(busWdata), .misoI(misoI),
    .mosiI(mosiI), .shiftQ(shiftQ), .rxBufQ(rxBufQ), .serOut(serOut)
  );

  always_comb begin
    mosiO    = serOut;
    misoO    = serOut;
    sckOe    = cfgQ.enable && cfgQ.master;
    mosiOe   = cfgQ.enable && cfgQ.master && !cfgQ.outDisable;
    misoOe   = slvActive && !cfgQ.outDisable;
    busRdata = (busAddr == ADDR_STAT) ? {flagQ, {PAD_W{1'b0}}, cfgQ} : rxBufQ;
  end

endmodule

// File: rtl/spi_byte_port_chk.sv
`timescale 1ns/1ps
module spi_byte_port_chk
  import spi_byte_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWr,
  input logic              busAddr,
  input logic [DATA_W-1:0] busRdata,
  input logic              sckO,
  input logic              mosiOe,
  input logic              misoOe,
  input strobes_t          stb,
  input cfg_t              cfgQ,
  input logic              flagQ,
  input logic              seenQ,
  input logic              busyQ,
  input logic [DATA_W-1:0] shiftQ
);

  p_idle_sck_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busyQ |-> !sckO);

  p_flag_source_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagQ) |-> $past(stb.capture));

  p_buf_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ADDR_DATA && $past(busAddr == ADDR_DATA) && !$past(stb.capture))
      |-> $stable(busRdata));

  p_write_block_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWr && busAddr == ADDR_DATA && flagQ && !seenQ && !stb.shiftBit)
      |=> $stable(shiftQ));

  p_clear_needs_status_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flagQ) |-> $past(seenQ));

  p_out_off_r6: assert property (@(posedge clk) disable iff (!rstN)
    cfgQ.outDisable |-> (!mosiOe && !misoOe));

  p_soft_desel_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cfgQ.softSelMgmt && cfgQ.softSelVal) |-> !misoOe);

endmodule

bind spi_byte_port spi_byte_port_chk #(.DATA_W(DATA_W)) chk_i (.*);

// File: tb/spi_byte_port_tb_top.sv
`timescale 1ns/1ps
module spi_byte_port_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic       mSel = 0, mWr = 0, mAddr = 0;
  logic [7:0] mWd = '0, mRd;
  logic       sSel = 0, sWr = 0, sAddr = 0;
  logic [7:0] sWd = '0, sRd;
  logic       ssPin = 1'b0;
  logic       mSck, mSckOe, mMosi, mMosiOe, mMiso, mMisoOe;
  logic       sSck, sSckOe, sMosi, sMosiOe, sMiso, sMisoOe;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  spi_byte_port dut_i (
    .clk(clk), .rstN(rstN), .busSel(mSel), .busWr(mWr), .busAddr(mAddr),
    .busWdata(mWd), .busRdata(mRd), .sckI(1'b0), .sckO(mSck), .sckOe(mSckOe),
    .mosiI(1'b0), .mosiO(mMosi), .mosiOe(mMosiOe), .misoI(sMiso), .misoO(mMiso),
    .misoOe(mMisoOe), .ssPinN(1'b1)
  );

  spi_byte_port peer_i (
    .clk(clk), .rstN(rstN), .busSel(sSel), .busWr(sWr), .busAddr(sAddr),
    .busWdata(sWd), .busRdata(sRd), .sckI(mSck), .sckO(sSck), .sckOe(sSckOe),
    .mosiI(mMosi), .mosiO(sMosi), .mosiOe(sMosiOe), .misoI(1'b0), .misoO(sMiso),
    .misoOe(sMisoOe), .ssPinN(ssPin)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input bit toS, input bit a, input logic [7:0] d);
    @(negedge clk);
    if (toS) begin sSel = 1; sWr = 1; sAddr = a; sWd = d; end
    else begin mSel = 1; mWr = 1; mAddr = a; mWd = d; end
    @(negedge clk);
    sSel = 0; sWr = 0; mSel = 0; mWr = 0;
  endtask

  task automatic busRead(input bit toS, input bit a, output logic [7:0] d);
    @(negedge clk);
    if (toS) begin sSel = 1; sWr = 0; sAddr = a; end
    else begin mSel = 1; mWr = 0; mAddr = a; end
    #1 d = toS ? sRd : mRd;
    @(negedge clk);
    sSel = 0; mSel = 0;
  endtask

  // samples 40 falling system edges after a master write
  task automatic watchWindow(output int rises, output int highs, output int viol);
    logic pSck, pMosi;
    rises = 0; highs = 0; viol = 0;
    pSck = mSck; pMosi = mMosi;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (mSck && !pSck) rises++;
      if (mSck) highs++;
      if (mMosi !== pMosi && !(pSck && !mSck)) viol++;
      pSck = mSck; pMosi = mMosi;
    end
  endtask

  task automatic clearBoth(output logic [7:0] mr, output logic [7:0] sr,
                           output logic [7:0] mst, output logic [7:0] sst);
    busRead(0, 1, mst);
    busRead(1, 1, sst);
    busRead(0, 0, mr);
    busRead(1, 0, sr);
  endtask

  task automatic xfer(input logic [7:0] mb, input logic [7:0] sb,
                      output logic [7:0] mr, output logic [7:0] sr,
                      output logic [7:0] mst, output logic [7:0] sst,
                      output int rises, output int highs, output int viol);
    busWrite(1, 0, sb);
    busWrite(0, 0, mb);
    watchWindow(rises, highs, viol);
    clearBoth(mr, sr, mst, sst);
  endtask

  task automatic report();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      report();
    end
  end

  initial begin
    logic [7:0] mr, sr, mst, sst, v;
    int rises, highs, viol;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // reset state
    busRead(0, 1, v);
    check("R6 reset status", v, 8'h00);
    check("R6 reset oe", {5'd0, mMosiOe, mSckOe, sMisoOe}, 8'h00);
    check("R1 reset sck idle", {7'd0, mSck}, 8'h00);

    busWrite(0, 1, 8'h03);
    busWrite(1, 1, 8'h01);
    #1;
    check("R6 enabled oe", {5'd0, mMosiOe, mSckOe, sMisoOe}, 8'h07);

    // basic transfer
    xfer(8'hA5, 8'h3C, mr, sr, mst, sst, rises, highs, viol);
    check("R1 sck rises", 8'(rises), 8'd8);
    check("R1 sck high cycles", 8'(highs), 8'd16);
    check("R9 mosi changes on falling edge", 8'(viol), 8'd0);
    check("R2 master flag", mst & 8'h80, 8'h80);
    check("R2 slave flag", sst & 8'h80, 8'h80);
    check("R9 master rx", mr, 8'h3C);
    check("R9 slave rx", sr, 8'hA5);
    busRead(0, 1, v);
    check("R5 flag cleared", v & 8'h80, 8'h00);

    // R3: buffer holds during next transfer
    busWrite(1, 0, 8'h22);
    busWrite(0, 0, 8'h11);
    repeat (15) @(negedge clk);
    busRead(0, 0, v);
    check("R3 master buffer mid transfer", v, 8'h3C);
    busRead(1, 0, v);
    check("R3 slave buffer mid transfer", v, 8'hA5);
    repeat (25) @(negedge clk);
    clearBoth(mr, sr, mst, sst);
    check("R3 master new rx", mr, 8'h22);
    check("R3 slave new rx", sr, 8'h11);

    // R4/R5: inhibited writes
    busWrite(1, 0, 8'h7E);
    busWrite(0, 0, 8'h81);
    repeat (40) @(negedge clk);
    busWrite(0, 0, 8'h3C);
    watchWindow(rises, highs, viol);
    check("R4 blocked write starts nothing", 8'(rises), 8'd0);
    busWrite(1, 0, 8'hC3);
    busRead(0, 0, v);
    check("R5 data read returns buffer", v, 8'h7E);
    busRead(0, 1, v);
    check("R5 data read alone keeps flag", v & 8'h80, 8'h80);
    busRead(0, 0, v);
    busRead(0, 1, v);
    check("R5 status then data clears flag", v & 8'h80, 8'h00);
    busRead(1, 1, v);
    busRead(1, 0, v);
    check("R4 slave rx before blocked write", v, 8'h81);
    busWrite(0, 0, 8'h55);
    watchWindow(rises, highs, viol);
    clearBoth(mr, sr, mst, sst);
    check("R4 blocked write left slave shift", mr, 8'h81);
    check("R4 slave rx after", sr, 8'h55);

    // R5: write accepted after status read
    busWrite(0, 0, 8'h18);
    repeat (40) @(negedge clk);
    busRead(1, 1, v);
    busWrite(1, 0, 8'h99);
    busRead(0, 1, v);
    busWrite(0, 0, 8'h66);
    watchWindow(rises, highs, viol);
    check("R5 released write runs", 8'(rises), 8'd8);
    clearBoth(mr, sr, mst, sst);
    check("R5 slave write accepted", mr, 8'h99);
    check("R5 master write accepted", sr, 8'h66);

    // R6: output disable
    busWrite(0, 1, 8'h07);
    busWrite(1, 1, 8'h05);
    #1;
    check("R6 outputs disabled", {6'd0, mMosiOe, sMisoOe}, 8'h00);
    check("R6 sck still enabled", {7'd0, mSckOe}, 8'h01);
    busWrite(0, 1, 8'h03);
    busWrite(1, 1, 8'h01);

    // R7: software select
    ssPin = 1'b1;
    busWrite(1, 1, 8'h09);
    xfer(8'hC9, 8'h36, mr, sr, mst, sst, rises, highs, viol);
    check("R7 soft select overrides pin", sr, 8'hC9);
    check("R7 soft select master rx", mr, 8'h36);
    ssPin = 1'b0;
    busWrite(1, 1, 8'h19);
    #1;
    check("R7 soft deselect oe", {7'd0, sMisoOe}, 8'h00);
    busWrite(0, 0, 8'h5A);
    watchWindow(rises, highs, viol);
    clearBoth(mr, sr, mst, sst);
    check("R7 deselected slave no flag", sst & 8'h80, 8'h00);
    check("R7 deselected slave buffer kept", sr, 8'hC9);
    busWrite(1, 1, 8'h01);

    // R8: deselect mid-byte
    busWrite(1, 0, 8'hB4);
    busWrite(0, 0, 8'hE7);
    repeat (17) @(negedge clk);
    ssPin = 1'b1;
    repeat (25) @(negedge clk);
    ssPin = 1'b0;
    busRead(1, 1, v);
    check("R8 aborted byte no flag", v & 8'h80, 8'h00);
    busRead(0, 1, v);
    busRead(0, 0, v);
    busWrite(0, 0, 8'h2D);
    watchWindow(rises, highs, viol);
    clearBoth(mr, sr, mst, sst);
    check("R8 full byte after reselect", sr, 8'h2D);
    check("R8 partial shift returned", mr, 8'h4E);

    // sweep all master bytes
    for (int i = 0; i < 256; i++) begin
      logic [7:0] mb, sb;
      mb = 8'(i);
      sb = 8'(i * 29 + 11);
      xfer(mb, sb, mr, sr, mst, sst, rises, highs, viol);
      check("R9 sweep master rx", mr, sb);
      check("R2 sweep slave rx", sr, mb);
      check("R2 sweep flags", {mst[7], sst[7]}, 8'h03);
    end

    report();
  end

endmodule